// File: doc/BRIEF.md
# NOR Flash Command State Machine

This block is a synthesizable model of the command side of a parallel NOR flash. A host drives chip-enable, write-enable and output-enable strobes with an address and a data word. A write cycle completes on the rising edge of write-enable while chip-enable is low, and the block decodes those cycles into commands. Every command is gated by a two-cycle key prefix. The decoded commands are word program, sector erase, chip erase, unlock bypass (with its exit), suspend and resume.

Program and erase run against a small internal word array. A program lasts a fixed number of clock cycles and then clears bits in the target word. An erase walks through its range one word per clock and writes all-ones. While an operation runs, a read returns a status word instead of array data, and the ready output is low. Sector protection, a low-supply inhibit flag and the reset input limit what the host can change. The array contents are undefined at power-up, so the host starts with a chip erase.

Read results leave on a valid-only stream. `rd_valid` pulses for one clock, one cycle after a completed output-enable falling edge, and `rd_data` holds the word. There is no ready signal: the block cannot be back-pressured, and the host must capture the word in the cycle `rd_valid` is high.

Top module: `nor_flash_cmd`

## Requirements
- R1: Key A (data 0xAA at address 0x555), then key B (data 0x55 at address 0x2AA), then 0xA0, then one address/data write starts a program. When `rdy` returns high, that word reads back as the programmed value.
- R2: A program stores the bitwise AND of the old word and the written data, so bits only ever go from 1 to 0.
- R3: Key A, key B, 0x20 enters bypass mode. In bypass mode, 0xA0 followed by one address/data write programs a word. 0x90 followed by 0x00 leaves bypass mode, after which a bare 0xA0 no longer programs.
- R4: While an operation runs, `rdy` is 0 and every read returns a status word. Bit 7 is the complement of data bit 7 during a program and 0 during an erase. Bit 6 changes between successive reads. All other bits are 0.
- R5: Key A, key B, 0x80, key A, key B, then 0x30 at an address in sector s sets every word of sector s to 0xFFFF. Other sectors keep their contents. The sector is address bits [7:6].
- R6: The same prefix followed by 0x10 at 0x555 erases every unprotected sector.
- R7: 0xB0 during a sector erase parks it and raises `rdy`. While it is parked, other sectors read as array data and can be programmed. A program aimed at the parked sector is refused. 0x30 resumes the erase, which then completes.
- R8: 0xB0 during a program parks it and raises `rdy`. While it is parked, reads return array data, all writes other than 0x30 are ignored, and 0x30 resumes and completes the program.
- R9: When `prot_mask[s]` is 1, program and erase leave sector s unchanged.
- R10: While `rst_n` is low, any running operation stops, `rdy` is 1 and `rd_valid` is 0. The decoder returns to read mode, and words not yet erased keep their values.
- R11: While `lv_inhibit` is 1, write cycles have no effect.
- R12: A key write with a wrong address or wrong data returns the decoder to read mode, and the following writes do not program.
- R13: `rd_valid` is a single-cycle pulse for each read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the bus strobes |
| rst_n | input | 1 | Active-low reset; aborts any operation |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write completes on its rising edge |
| oe_n | input | 1 | Output enable, active low; a read starts on its falling edge |
| addr | input | BUS_AW (11) | Word address |
| dq_in | input | DATA_W (16) | Write data and command byte (low 8 bits) |
| lv_inhibit | input | 1 | Low-supply flag that blocks writes |
| prot_mask | input | 2**SECT_AW (4) | One protection bit per sector |
| rd_valid | output | 1 | Read result valid, one clock |
| rd_data | output | DATA_W (16) | Array word or status word |
| rdy | output | 1 | High when no program or erase is running |

## Verification
The interesting coincidence is a status read that lands in the same cycle a program finishes and writes the array. The status/data decision and the array update then fall in one clock. To provoke it, the bench polls a programmed word back-to-back across the whole program time. Each result is judged as either a valid status word (bit 7 inverted, only bit 6 otherwise set) or the final data. Once final data has appeared, no status word may follow. A second coincidence is a suspend arriving while an erase is still walking. It is judged by reading a not-yet-erased word of the parked sector.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [3:0] {
    D_READ, D_UNL1, D_UNL2, D_PADDR,
    D_ESET, D_EUNL1, D_EUNL2,
    D_BYP, D_BPADDR, D_BEXIT
  } dec_st_t;

  typedef enum logic [2:0] {
    E_IDLE, E_PGM, E_ERS, E_ESUSP, E_PSUSP, E_SPGM
  } eng_st_t;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [7:0]  KEY_A      = 8'hAA;
  localparam logic [7:0]  KEY_B      = 8'h55;
  localparam logic [7:0]  OP_PGM     = 8'hA0;
  localparam logic [7:0]  OP_ERSETUP = 8'h80;
  localparam logic [7:0]  OP_BYPASS  = 8'h20;
  localparam logic [7:0]  OP_SUSP    = 8'hB0;
  localparam logic [7:0]  OP_RESUME  = 8'h30;
  localparam logic [7:0]  OP_CHIP    = 8'h10;
  localparam logic [7:0]  OP_BYPX1   = 8'h90;
  localparam logic [7:0]  OP_BYPX2   = 8'h00;

  function automatic logic op_running(eng_st_t s);
    return (s == E_PGM) || (s == E_ERS) || (s == E_SPGM);
  endfunction

endpackage

// File: rtl/nfc_bus_sync.sv
module nfc_bus_sync #(
  parameter int BUS_AW = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [BUS_AW-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [BUS_AW-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic ce1, we1, oe1, we2, oe2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce1 <= 1'b1;
      we1 <= 1'b1;
      oe1 <= 1'b1;
      we2 <= 1'b1;
      oe2 <= 1'b1;
    end else begin
      ce1 <= ce_n;
      we1 <= we_n;
      oe1 <= oe_n;
      we2 <= we1;
      oe2 <= oe1;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_in;
    data_q <= data_in;
  end

  assign wr_stb = !we2 && we1 && !ce1;
  assign rd_stb = oe2 && !oe1 && !ce1;

endmodule

// File: rtl/nfc_cmd_decode.sv
module nfc_cmd_decode import nfc_pkg::*; #(
  parameter int BUS_AW  = 11,
  parameter int DATA_W  = 16,
  parameter int ARR_AW  = 8,
  parameter int SECT_AW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [BUS_AW-1:0]       addr,
  input  logic [DATA_W-1:0]       data,
  input  logic                    lv_inhibit,
  input  eng_st_t                 eng_st,
  input  logic [SECT_AW-1:0]      susp_sect,
  input  logic [(1<<SECT_AW)-1:0] prot,
  output logic                    start_pgm,
  output logic                    start_sers,
  output logic                    start_cers,
  output logic                    suspend,
  output logic                    resume,
  output logic [ARR_AW-1:0]       pgm_addr,
  output logic [DATA_W-1:0]       pgm_data,
  output logic [SECT_AW-1:0]      ers_sect
);
  dec_st_t st, nxt;
  logic wr, key_a, key_b, pgm_ok, idle;
  logic [7:0]  cmd;
  logic [10:0] ka;
  logic [SECT_AW-1:0] sect;

  assign wr       = wr_stb && !lv_inhibit;
  assign cmd      = data[7:0];
  assign ka       = addr[10:0];
  assign sect     = addr[ARR_AW-1 -: SECT_AW];
  assign key_a    = (ka == KEY_ADDR_A) && (cmd == KEY_A);
  assign key_b    = (ka == KEY_ADDR_B) && (cmd == KEY_B);
  assign idle     = (eng_st == E_IDLE);
  assign pgm_ok   = !prot[sect] && !((eng_st == E_ESUSP) && (sect == susp_sect));
  assign pgm_addr = addr[ARR_AW-1:0];
  assign pgm_data = data;
  assign ers_sect = sect;

  always_comb begin
    nxt        = st;
    start_pgm  = 1'b0;
    start_sers = 1'b0;
    start_cers = 1'b0;
    suspend    = 1'b0;
    resume     = 1'b0;
    if (wr) begin
      if (op_running(eng_st)) begin
        if (cmd == OP_SUSP && eng_st != E_SPGM) suspend = 1'b1;
      end else if (eng_st == E_PSUSP) begin
        if (cmd == OP_RESUME) resume = 1'b1;
      end else begin
        case (st)
          D_READ: begin
            if (cmd == OP_RESUME && eng_st == E_ESUSP) resume = 1'b1;
            else if (key_a) nxt = D_UNL1;
          end
          D_UNL1:  nxt = key_b ? D_UNL2 : D_READ;
          D_UNL2: begin
            if (cmd == OP_PGM)                 nxt = D_PADDR;
            else if (cmd == OP_ERSETUP && idle) nxt = D_ESET;
            else if (cmd == OP_BYPASS && idle)  nxt = D_BYP;
            else                                nxt = D_READ;
          end
          D_PADDR: begin
            nxt       = D_READ;
            start_pgm = pgm_ok;
          end
          D_ESET:  nxt = key_a ? D_EUNL1 : D_READ;
          D_EUNL1: nxt = key_b ? D_EUNL2 : D_READ;
          D_EUNL2: begin
            nxt = D_READ;
            if (cmd == OP_CHIP && ka == KEY_ADDR_A) start_cers = 1'b1;
            else if (cmd == OP_RESUME && !prot[sect]) start_sers = 1'b1;
          end
          D_BYP: begin
            if (cmd == OP_PGM)         nxt = D_BPADDR;
            else if (cmd == OP_BYPX1)  nxt = D_BEXIT;
          end
          D_BPADDR: begin
            nxt       = D_BYP;
            start_pgm = pgm_ok;
          end
          D_BEXIT: nxt = (cmd == OP_BYPX2) ? D_READ : D_BYP;
          default: nxt = D_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= D_READ;
    else        st <= nxt;
  end

  AST_LV_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    lv_inhibit |-> !(start_pgm || start_sers || start_cers || suspend || resume)); // R11

endmodule

// File: rtl/nfc_op_engine.sv
module nfc_op_engine import nfc_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int ARR_AW  = 8,
  parameter int SECT_AW = 2,
  parameter int PGM_CYC = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_pgm,
  input  logic                    start_sers,
  input  logic                    start_cers,
  input  logic                    suspend,
  input  logic                    resume,
  input  logic [ARR_AW-1:0]       pgm_addr,
  input  logic [DATA_W-1:0]       pgm_data,
  input  logic [SECT_AW-1:0]      ers_sect,
  input  logic [(1<<SECT_AW)-1:0] prot,
  input  logic [DATA_W-1:0]       mem_rdata,
  output eng_st_t                 st,
  output logic [SECT_AW-1:0]      susp_sect,
  output logic                    pgm_bit7,
  output logic                    mem_we,
  output logic [ARR_AW-1:0]       mem_waddr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [ARR_AW-1:0]       mem_raddr
);
  localparam int SOFF  = ARR_AW - SECT_AW;
  localparam int CNT_W = (PGM_CYC > 1) ? $clog2(PGM_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PGM_CYC - 1);

  logic [ARR_AW-1:0] paddr, eptr, eend;
  logic [DATA_W-1:0] pdata;
  logic [CNT_W-1:0]  pcnt;
  logic echip, pgm_done, ers_last, ers_park, ers_word;

  assign pgm_done  = ((st == E_PGM) || (st == E_SPGM)) && (pcnt == CNT_LAST);
  assign ers_last  = (eptr == eend);
  assign ers_park  = suspend && !echip && !ers_last;
  assign ers_word  = (st == E_ERS) && !ers_park;
  assign mem_we    = pgm_done || (ers_word && !prot[eptr[ARR_AW-1 -: SECT_AW]]);
  assign mem_waddr = (st == E_ERS) ? eptr : paddr;
  assign mem_wdata = (st == E_ERS) ? {DATA_W{1'b1}} : (mem_rdata & pdata);
  assign mem_raddr = paddr;
  assign susp_sect = eptr[ARR_AW-1 -: SECT_AW];
  assign pgm_bit7  = pdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= E_IDLE;
      paddr <= '0;
      pdata <= '0;
      pcnt  <= '0;
      eptr  <= '0;
      eend  <= '0;
      echip <= 1'b0;
    end else begin
      case (st)
        E_IDLE: begin
          if (start_pgm) begin
            st    <= E_PGM;
            paddr <= pgm_addr;
            pdata <= pgm_data;
            pcnt  <= '0;
          end else if (start_sers) begin
            st    <= E_ERS;
            eptr  <= {ers_sect, {SOFF{1'b0}}};
            eend  <= {ers_sect, {SOFF{1'b1}}};
            echip <= 1'b0;
          end else if (start_cers) begin
            st    <= E_ERS;
            eptr  <= '0;
            eend  <= '1;
            echip <= 1'b1;
          end
        end
        E_PGM: begin
          if (pgm_done)     st <= E_IDLE;
          else if (suspend) st <= E_PSUSP;
          else              pcnt <= pcnt + 1'b1;
        end
        E_SPGM: begin
          if (pgm_done) st <= E_ESUSP;
          else          pcnt <= pcnt + 1'b1;
        end
        E_ERS: begin
          if (ers_park)      st <= E_ESUSP;
          else if (ers_last) st <= E_IDLE;
          else               eptr <= eptr + 1'b1;
        end
        E_ESUSP: begin
          if (resume) st <= E_ERS;
          else if (start_pgm) begin
            st    <= E_SPGM;
            paddr <= pgm_addr;
            pdata <= pgm_data;
            pcnt  <= '0;
          end
        end
        E_PSUSP: if (resume) st <= E_PGM;
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_ERASE_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_ERS && $past(st) == E_ERS) |-> (eptr == $past(eptr) + 1'b1)); // R5
  AST_PARKED_ERASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_ESUSP && $past(st) == E_ESUSP) |-> $stable(eptr)); // R7
  AST_PARKED_PGM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_PSUSP) |-> !mem_we); // R8

endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
  parameter int DATA_W = 16,
  parameter int ARR_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ARR_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ARR_AW-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ARR_AW-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ARR_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  AST_WRITE_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata != {DATA_W{1'b1}}) |-> ((wdata & ~mem[waddr]) == '0)); // R2

endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd import nfc_pkg::*; #(
  parameter int BUS_AW  = 11,
  parameter int DATA_W  = 16,
  parameter int ARR_AW  = 8,
  parameter int SECT_AW = 2,
  parameter int PGM_CYC = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [BUS_AW-1:0]       addr,
  input  logic [DATA_W-1:0]       dq_in,
  input  logic                    lv_inhibit,
  input  logic [(1<<SECT_AW)-1:0] prot_mask,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rdy
);
  logic              wr_stb, rd_stb;
  logic [BUS_AW-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic start_pgm, start_sers, start_cers, suspend, resume;
  logic [ARR_AW-1:0]  pgm_addr, mem_waddr, mem_raddr;
  logic [DATA_W-1:0]  pgm_data, mem_wdata, mem_rd_eng, mem_rd_bus, status;
  logic [SECT_AW-1:0] ers_sect, susp_sect;
  logic mem_we, pgm_bit7, busy, tog;
  eng_st_t eng_st;

  nfc_bus_sync #(.BUS_AW(BUS_AW), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr_in(addr), .data_in(dq_in), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .addr_q(addr_q), .data_q(data_q));

  nfc_cmd_decode #(.BUS_AW(BUS_AW), .DATA_W(DATA_W), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr_q), .data(data_q),
    .lv_inhibit(lv_inhibit), .eng_st(eng_st), .susp_sect(susp_sect), .prot(prot_mask),
    .start_pgm(start_pgm), .start_sers(start_sers), .start_cers(start_cers),
    .suspend(suspend), .resume(resume), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .ers_sect(ers_sect));

  nfc_op_engine #(.DATA_W(DATA_W), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW), .PGM_CYC(PGM_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_pgm(start_pgm), .start_sers(start_sers),
    .start_cers(start_cers), .suspend(suspend), .resume(resume), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .ers_sect(ers_sect), .prot(prot_mask), .mem_rdata(mem_rd_eng),
    .st(eng_st), .susp_sect(susp_sect), .pgm_bit7(pgm_bit7), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr));

  nfc_array #(.DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(mem_raddr), .rdata_a(mem_rd_eng),
    .raddr_b(addr_q[ARR_AW-1:0]), .rdata_b(mem_rd_bus));

  assign busy = op_running(eng_st);
  assign rdy  = !busy;

  always_comb begin
    status    = '0;
    status[7] = (eng_st == E_ERS) ? 1'b0 : !pgm_bit7;
    status[6] = tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tog      <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        rd_data <= busy ? status : mem_rd_bus;
        if (busy) tog <= !tog;
      end
    end
  end

  AST_PROTECTED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !prot_mask[mem_waddr[ARR_AW-1 -: SECT_AW]]); // R9
  AST_READ_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R13

endmodule

// File: tb/nor_flash_cmd_test.sv
module nor_flash_cmd_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic lv_inhibit = 1'b0;
  logic [3:0] prot_mask = '0;
  logic rd_valid, rdy;
  logic [15:0] rd_data;

  int checks = 0, fails = 0, rv_cnt = 0;
  logic [15:0] exp_q[$], msk_q[$];
  string tag_q[$];
  bit cap_en = 1'b0, cap_got = 1'b0;
  logic [15:0] cap_val;

  always #10 clk = !clk;

  nor_flash_cmd uut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .lv_inhibit(lv_inhibit), .prot_mask(prot_mask),
    .rd_valid(rd_valid), .rd_data(rd_data), .rdy(rdy));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: scoreboard pop or capture
  always @(negedge clk) begin
    if (rd_valid) begin
      rv_cnt++;
      if (cap_en) begin
        cap_val = rd_data;
        cap_got = 1'b1;
      end else if (exp_q.size() == 0) begin
        chk(1'b0, "R13 unexpected read", rd_data, 16'h0);
      end else begin
        logic [15:0] e, m;
        string t;
        e = exp_q.pop_front();
        m = msk_q.pop_front();
        t = tag_q.pop_front();
        chk((rd_data & m) == (e & m), t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all-reqs act=hung exp=done");
    report();
  end

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    we_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    ce_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic strobe_read(input logic [10:0] a);
    @(posedge clk); #1;
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(posedge clk); #1;
    oe_n = 1'b1; ce_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [10:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    msk_q.push_back(16'hFFFF);
    tag_q.push_back(t);
    strobe_read(a);
  endtask

  task automatic rd_cap(input logic [10:0] a, output logic [15:0] v);
    cap_en = 1'b1;
    cap_got = 1'b0;
    strobe_read(a);
    chk(cap_got, "R13 capture", 16'h0, 16'h1);
    v = cap_val;
    cap_en = 1'b0;
  endtask

  task automatic wait_rdy(input string t);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rdy) break;
    end
    chk(rdy, t, {15'h0, rdy}, 16'h1);
  endtask

  task automatic unlock;
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  task automatic prog(input logic [10:0] a, input logic [15:0] d);
    unlock();
    wr(11'h555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase_prefix;
    unlock();
    wr(11'h555, 16'h0080);
    unlock();
  endtask

  initial begin
    logic [15:0] v1, v2;
    int n0;
    bit got_final;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdy == 1'b1 && rd_valid == 1'b0, "R10 reset state", {14'h0, rdy, rd_valid}, 16'h2);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R6 chip erase with status check (R4)
    erase_prefix();
    wr(11'h555, 16'h0010);
    @(negedge clk);
    chk(!rdy, "R4 busy on chip erase", {15'h0, rdy}, 16'h0);
    rd_cap(11'h000, v1);
    chk((v1 & 16'hFFBF) == 16'h0, "R4 erase status", v1, 16'h0);
    wait_rdy("R6 chip erase done");
    rd(11'h000, 16'hFFFF, "R6 word 0x00");
    rd(11'h0FF, 16'hFFFF, "R6 word 0xFF");

    // R1 program, R4 toggle
    prog(11'h010, 16'h1234);
    rd_cap(11'h010, v1);
    rd_cap(11'h010, v2);
    chk((v1 & 16'hFFBF) == 16'h0080, "R4 program status DQ7", v1, 16'h0080);
    chk(v1[6] != v2[6], "R4 toggle bit", v2, v1 ^ 16'h0040);
    wait_rdy("R1 program done");
    rd(11'h010, 16'h1234, "R1 programmed word");

    // R2 only clears bits
    prog(11'h010, 16'hFF0F);
    wait_rdy("R2 program done");
    rd(11'h010, 16'h1204, "R2 AND of old and new");

    // R12 broken key sequence
    wr(11'h555, 16'h00AA);
    wr(11'h123, 16'h0055);
    wr(11'h555, 16'h00A0);
    wr(11'h020, 16'h0000);
    @(negedge clk);
    chk(rdy, "R12 no operation started", {15'h0, rdy}, 16'h1);
    rd(11'h020, 16'hFFFF, "R12 word untouched");

    // R3 bypass
    unlock();
    wr(11'h555, 16'h0020);
    wr(11'h000, 16'h00A0);
    wr(11'h030, 16'hABCD);
    wait_rdy("R3 bypass program done");
    wr(11'h000, 16'h00A0);
    wr(11'h031, 16'h5555);
    wait_rdy("R3 second bypass program");
    rd(11'h030, 16'hABCD, "R3 bypass word 0x30");
    rd(11'h031, 16'h5555, "R3 bypass word 0x31");
    wr(11'h000, 16'h0090);
    wr(11'h000, 16'h0000);
    wr(11'h000, 16'h00A0);
    wr(11'h032, 16'h0000);
    @(negedge clk);
    chk(rdy, "R3 after exit no start", {15'h0, rdy}, 16'h1);
    rd(11'h032, 16'hFFFF, "R3 after exit word untouched");

    // R9 protection
    prog(11'h041, 16'h0F0F);
    wait_rdy("R9 setup program");
    prot_mask = 4'b0010;
    prog(11'h040, 16'h0000);
    @(negedge clk);
    chk(rdy, "R9 protected program refused", {15'h0, rdy}, 16'h1);
    erase_prefix();
    wr(11'h040, 16'h0030);
    @(negedge clk);
    chk(rdy, "R9 protected erase refused", {15'h0, rdy}, 16'h1);
    rd(11'h040, 16'hFFFF, "R9 protected word 0x40");
    rd(11'h041, 16'h0F0F, "R9 protected word 0x41");
    prot_mask = 4'b0000;

    // R5 sector erase of sector 0
    erase_prefix();
    wr(11'h000, 16'h0030);
    wait_rdy("R5 sector erase done");
    rd(11'h010, 16'hFFFF, "R5 erased 0x10");
    rd(11'h030, 16'hFFFF, "R5 erased 0x30");
    rd(11'h041, 16'h0F0F, "R5 other sector kept");

    // R7 erase suspend
    prog(11'h005, 16'h0000);
    wait_rdy("R7 setup a");
    prog(11'h03F, 16'h0000);
    wait_rdy("R7 setup b");
    erase_prefix();
    wr(11'h000, 16'h0030);
    wr(11'h000, 16'h00B0);
    @(negedge clk);
    chk(rdy, "R7 parked ready", {15'h0, rdy}, 16'h1);
    rd(11'h03F, 16'h0000, "R7 walk frozen before 0x3F");
    rd(11'h041, 16'h0F0F, "R7 other sector readable");
    prog(11'h042, 16'h2222);
    wait_rdy("R7 nested program");
    rd(11'h042, 16'h2222, "R7 nested program result");
    prog(11'h03E, 16'h0000);
    @(negedge clk);
    chk(rdy, "R7 parked sector refused", {15'h0, rdy}, 16'h1);
    wr(11'h000, 16'h0030);
    @(negedge clk);
    chk(!rdy, "R7 resumed busy", {15'h0, rdy}, 16'h0);
    wait_rdy("R7 erase completes");
    rd(11'h03F, 16'hFFFF, "R7 erased 0x3F");
    rd(11'h005, 16'hFFFF, "R7 erased 0x05");

    // R8 program suspend
    prog(11'h050, 16'h0000);
    wr(11'h000, 16'h00B0);
    @(negedge clk);
    chk(rdy, "R8 parked ready", {15'h0, rdy}, 16'h1);
    rd(11'h041, 16'h0F0F, "R8 read while parked");
    prog(11'h051, 16'h0000);
    @(negedge clk);
    chk(rdy, "R8 program ignored", {15'h0, rdy}, 16'h1);
    wr(11'h000, 16'h0030);
    @(negedge clk);
    chk(!rdy, "R8 resumed busy", {15'h0, rdy}, 16'h0);
    wait_rdy("R8 program completes");
    rd(11'h050, 16'h0000, "R8 resumed word");
    rd(11'h051, 16'hFFFF, "R8 ignored word");

    // R11 low-supply inhibit
    lv_inhibit = 1'b1;
    prog(11'h060, 16'h0000);
    @(negedge clk);
    chk(rdy, "R11 no start", {15'h0, rdy}, 16'h1);
    lv_inhibit = 1'b0;
    rd(11'h060, 16'hFFFF, "R11 word untouched");

    // R10 reset during erase
    prog(11'h07F, 16'h0000);
    wait_rdy("R10 setup");
    erase_prefix();
    wr(11'h040, 16'h0030);
    repeat (6) @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rdy && !rd_valid, "R10 ready under reset", {14'h0, rdy, rd_valid}, 16'h2);
    #1 rst_n = 1'b1;
    rd(11'h07F, 16'h0000, "R10 partial erase kept");
    prog(11'h070, 16'h0000);
    wait_rdy("R10 program after reset");
    rd(11'h070, 16'h0000, "R10 read mode after reset");

    // R13 pulse count
    n0 = rv_cnt;
    rd(11'h070, 16'h0000, "R13 single read");
    chk(rv_cnt == n0 + 1, "R13 one pulse per read", 16'(rv_cnt - n0), 16'h1);

    // R4/R1 polling across program completion
    prog(11'h008, 16'h00F0);
    got_final = 1'b0;
    for (int i = 0; i < 20; i++) begin
      rd_cap(11'h008, v1);
      if (v1 == 16'h00F0) got_final = 1'b1;
      else chk(!got_final && (v1 & 16'hFFBF) == 16'h0, "R4 poll status", v1, 16'h0000);
    end
    chk(got_final, "R1 poll reaches data", {15'h0, got_final}, 16'h1);

    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R13 all reads returned", 16'(exp_q.size()), 16'h0);
    report();
  end

endmodule